// File: doc/BRIEF.md
# Serial Bitstream Configuration Sequencer

This block loads a configuration image into a target programmable device over a one-bit serial link. It takes bytes from a valid/ready stream and shifts them out on a data line, most significant bit first, with a configuration clock that it generates itself. Before any data it runs the reset handshake. It pulls the target's active-low program line low and waits for the target's active-low init line to answer. It then releases program and waits for init to return high. When the data runs out, or when the target signals done early, the block clocks all-ones filler bytes until done and init are both high. It then sends one more filler byte and reports the outcome.

A host pulses `start_i` with the image length on `len_i`. It keeps feeding bytes while `busy_o` is high and reads `result_o` once `busy_o` drops. Timeouts are counted in microseconds. A free-running divider makes a one-microsecond tick from the system clock. An abort input returns the block to idle at any point.

Top module: `cfg_serial_loader`

## Requirements
- R1: After `start_i`, `prog_n_o` goes low. It stays low for at least `PROG_CYC` system cycles and until `init_n_i` has been seen low. Only then is it released.
- R2: If init does not fall within `INIT_TMO_US` microseconds of start while program is low, the load ends with result 2. The same result is given when init does not rise within `INIT_TMO_US` of the release. In both cases `prog_n_o` is left high.
- R3: `ready_o` stays low, and no clock edge is sent, until init has returned high after the release.
- R4: Each byte is shifted out MSB first. `dout_o` is set while `cclk_o` is low and held while it is high. The target takes the bit on the rising edge. Each clock phase lasts at least `HALF_CYC` (at least 2) system cycles, and `cclk_o` idles high.
- R5: At most `len_i` bytes are accepted, each on a cycle with `valid_i` and `ready_o` both high. When the stream is not cut short, exactly `len_i` bytes are accepted.
- R6: The init line is checked before each byte. If init is low there, the load stops with result 3, and `err_off_o` gives the number of bytes already accepted.
- R7: If done is high before the stream is complete, the block accepts no further bytes and goes to the completion phase without error.
- R8: After the data, the block sends 0xFF bytes until done and init are both high. It then sends one more 0xFF byte (8 rising edges) and ends with result 1.
- R9: If the completion phase lasts more than `DONE_TMO_US` microseconds without done and init both high, the load ends with result 4.
- R10: `abort_i` ends any load on the next edge. Result becomes 5, `prog_n_o` and `cclk_o` go high, and `busy_o` falls.
- R11: After reset, `prog_n_o` and `cclk_o` are high, and `busy_o`, `ready_o` and `result_o` are 0. `busy_o` is high from the edge after `start_i` until the result is set. Result 0 means no result yet; the result is held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled in idle |
| abort_i | input | 1 | Abort, returns to idle |
| len_i | input | LEN_W | Image length in bytes, sampled with start |
| byte_i | input | 8 | Stream data byte |
| valid_i | input | 1 | Stream byte valid |
| ready_o | output | 1 | Stream byte accepted when valid |
| prog_n_o | output | 1 | Target program line, active low |
| cclk_o | output | 1 | Configuration clock, idle high |
| dout_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Target init line, active low, asynchronous |
| done_i | input | 1 | Target done line, asynchronous |
| busy_o | output | 1 | Load in progress |
| result_o | output | 3 | 0 none, 1 ok, 2 init timeout, 3 load error, 4 done timeout, 5 aborted |
| err_off_o | output | LEN_W | Bytes accepted before a load error |

## Verification
The checks that fall in the same cycle are the init-error check and the done check. Both happen at a byte boundary, and the next byte handshake is decided in that cycle too. The bench holds the stream still after a chosen byte, then drives init low or done high, and only then offers the next byte. So the block meets the fault exactly at a boundary with a byte waiting. An init fault is judged by result 3 with an error offset equal to the bytes already taken. An early done is judged by the stream stopping at that count, one 0xFF byte following, and a clean result 1. Random stream gaps also let the final-byte handshake fall in the same cycle as the filler decision.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [2:0] {
    RES_NONE     = 3'd0,
    RES_OK       = 3'd1,
    RES_INIT_TMO = 3'd2,
    RES_LOAD_ERR = 3'd3,
    RES_DONE_TMO = 3'd4,
    RES_ABORT    = 3'd5
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_REL, S_LOAD, S_POST, S_TAIL
  } st_e;
endpackage

// File: rtl/cfg_us_tick.sv
module cfg_us_tick #(
  parameter int DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == W'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int TW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q;

  assign exp_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !exp_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/cfg_shift_out.sv
module cfg_shift_out #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       idle_o,
  output logic       cclk_o,
  output logic       dout_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [HW-1:0] ph_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          act_q, cclk_q, dout_q;

  assign idle_o = !act_q;
  assign cclk_o = cclk_q;
  assign dout_o = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      act_q  <= 1'b0;
      cclk_q <= 1'b1;
      dout_q <= 1'b1;
    end else if (clr_i) begin
      ph_q   <= '0;
      act_q  <= 1'b0;
      cclk_q <= 1'b1;
    end else if (load_i && !act_q) begin
      sh_q   <= byte_i;
      bit_q  <= '0;
      ph_q   <= '0;
      act_q  <= 1'b1;
      cclk_q <= 1'b0;
      dout_q <= byte_i[7];
    end else if (act_q) begin
      if (ph_q == HW'(HALF_CYC - 1)) begin
        ph_q <= '0;
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else if (bit_q == 3'd7) begin
          act_q <= 1'b0;
        end else begin
          bit_q  <= bit_q + 1'b1;
          sh_q   <= {sh_q[6:0], 1'b0};
          dout_q <= sh_q[6];
          cclk_q <= 1'b0;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // data may only change while the clock is low
  assert_dout_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_q |=> (!cclk_q || $stable(dout_q)));

  // each clock phase lasts at least two system cycles
  assert_high_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_q) |=> cclk_q);
  assert_low_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cclk_q) && !clr_i) |=> !cclk_q);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_ld_pkg::*;
#(
  parameter int US_DIV      = 200,
  parameter int PROG_CYC    = 64,
  parameter int HALF_CYC    = 4,
  parameter int INIT_TMO_US = 500000,
  parameter int DONE_TMO_US = 200000,
  parameter int LEN_W       = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             dout_o,
  input  logic             init_n_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic [2:0]       result_o,
  output logic [LEN_W-1:0] err_off_o
);
  localparam int TMO_MAX = (INIT_TMO_US > DONE_TMO_US) ? INIT_TMO_US : DONE_TMO_US;
  localparam int TW      = $clog2(TMO_MAX + 1);
  localparam int PW      = $clog2(PROG_CYC + 1);

  st_e              state_q;
  res_e             res_q;
  logic [LEN_W-1:0] len_q, cnt_q, erroff_q;
  logic [PW-1:0]    hold_q;
  logic             prog_n_q;

  logic       tick, tmr_clr, tmr_exp;
  logic [TW-1:0] tmr_lim;
  logic [1:0] sync_q;
  logic       init_n_s, done_s;
  logic       sh_load, sh_idle;
  logic [7:0] sh_byte;
  logic       hold_ok, prog_go, fin_ok;

  cfg_us_tick #(.DIV(US_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  cfg_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .tick_i(tick),
    .limit_i(tmr_lim), .exp_o(tmr_exp)
  );

  cfg_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i, .rst_ni, .d_i({done_i, init_n_i}), .q_o(sync_q)
  );
  assign init_n_s = sync_q[0];
  assign done_s   = sync_q[1];

  cfg_shift_out #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk_i, .rst_ni, .clr_i(abort_i), .load_i(sh_load), .byte_i(sh_byte),
    .idle_o(sh_idle), .cclk_o(cclk_o), .dout_o(dout_o)
  );

  assign hold_ok = (hold_q == PW'(PROG_CYC - 1));
  assign prog_go = hold_ok && !init_n_s;
  assign fin_ok  = done_s && init_n_s;

  always_comb begin
    ready_o = (state_q == S_LOAD) && sh_idle && !abort_i && (cnt_q != len_q)
              && !done_s && init_n_s;
    sh_load = 1'b0;
    sh_byte = byte_i;
    if (ready_o && valid_i) begin
      sh_load = 1'b1;
    end else if (state_q == S_POST && sh_idle && !abort_i && (fin_ok || !tmr_exp)) begin
      sh_load = 1'b1;
      sh_byte = 8'hFF;
    end
    tmr_lim = (state_q == S_POST || state_q == S_TAIL) ? TW'(DONE_TMO_US) : TW'(INIT_TMO_US);
    tmr_clr = (state_q == S_IDLE) || (state_q == S_LOAD) || (state_q == S_PROG && prog_go);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      res_q    <= RES_NONE;
      len_q    <= '0;
      cnt_q    <= '0;
      erroff_q <= '0;
      hold_q   <= '0;
      prog_n_q <= 1'b1;
    end else if (abort_i) begin
      if (state_q != S_IDLE) res_q <= RES_ABORT;
      state_q  <= S_IDLE;
      prog_n_q <= 1'b1;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_PROG;
          len_q    <= len_i;
          cnt_q    <= '0;
          hold_q   <= '0;
          erroff_q <= '0;
          res_q    <= RES_NONE;
          prog_n_q <= 1'b0;
        end
        S_PROG: begin
          if (!hold_ok) hold_q <= hold_q + 1'b1;
          if (tmr_exp) begin
            state_q  <= S_IDLE;
            res_q    <= RES_INIT_TMO;
            prog_n_q <= 1'b1;
          end else if (prog_go) begin
            state_q  <= S_REL;
            prog_n_q <= 1'b1;
          end
        end
        S_REL: begin
          if (tmr_exp) begin
            state_q <= S_IDLE;
            res_q   <= RES_INIT_TMO;
          end else if (init_n_s) begin
            state_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (sh_load) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (sh_idle) begin
            if (done_s || cnt_q == len_q) begin
              state_q <= S_POST;
            end else if (!init_n_s) begin
              state_q  <= S_IDLE;
              res_q    <= RES_LOAD_ERR;
              erroff_q <= cnt_q;
            end
          end
        end
        S_POST: if (sh_idle) begin
          if (fin_ok) begin
            state_q <= S_TAIL;
          end else if (tmr_exp) begin
            state_q <= S_IDLE;
            res_q   <= RES_DONE_TMO;
          end
        end
        S_TAIL: if (sh_idle) begin
          state_q <= S_IDLE;
          res_q   <= RES_OK;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign prog_n_o  = prog_n_q;
  assign busy_o    = (state_q != S_IDLE);
  assign result_o  = res_q;
  assign err_off_o = erroff_q;

  // length of the current program-low run, for the pulse-width check
  logic [PW-1:0] lo_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              lo_cnt_q <= '0;
    else if (prog_n_q)                        lo_cnt_q <= '0;
    else if (lo_cnt_q != PW'(PROG_CYC))       lo_cnt_q <= lo_cnt_q + 1'b1;
  end

  assert_prog_min_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(prog_n_q) && !$past(abort_i)) |-> (lo_cnt_q >= PW'(PROG_CYC)));

  assert_ready_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (prog_n_q && cclk_o));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_q);

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (prog_n_q && cclk_o && !busy_o));

  assert_idle_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (prog_n_q && !ready_o));
endmodule

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
  localparam int LEN_W    = 8;
  localparam int PROG_CYC = 6;
  localparam int INIT_US  = 50;
  localparam int DONE_US  = 300;
  localparam int US_DIV   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0] byte_i = '0;
  logic valid_i = 1'b0;
  logic ready_o, prog_n_o, cclk_o, dout_o, busy_o;
  logic init_n_i, done_i;
  logic [2:0] result_o;
  logic [LEN_W-1:0] err_off_o;

  always #2.5ns clk_i = ~clk_i;

  cfg_serial_loader #(
    .US_DIV(US_DIV), .PROG_CYC(PROG_CYC), .HALF_CYC(2),
    .INIT_TMO_US(INIT_US), .DONE_TMO_US(DONE_US), .LEN_W(LEN_W)
  ) u_cfg_serial_loader (
    .clk_i, .rst_ni, .start_i, .abort_i, .len_i, .byte_i, .valid_i, .ready_o,
    .prog_n_o, .cclk_o, .dout_o, .init_n_i, .done_i, .busy_o, .result_o, .err_off_o
  );

  // test controls (written by the main process only)
  bit mdl_rst = 1'b0, no_init_low = 1'b0, stuck_rel = 1'b0;
  bit force_init_lo = 1'b0, force_done = 1'b0, feed_en = 1'b0, fin = 1'b0;
  int done_at = -1, feed_lim = 0;
  logic [7:0] tx [0:15];

  // target model state (written by the model only)
  logic [7:0] rx [0:63];
  int rx_n, bitc, edges_after, lo_ctr, hi_ctr, last_lo, acc_n;
  bit model_init = 1'b1, model_done = 1'b0, rel_pend = 1'b0, prev_cclk = 1'b1;
  logic [7:0] shreg;

  int n_chk = 0, n_fail = 0;

  assign init_n_i = model_init && !force_init_lo;
  assign done_i   = model_done || force_done;

  always @(posedge clk_i) begin
    if (mdl_rst)                acc_n <= 0;
    else if (valid_i && ready_o) acc_n <= acc_n + 1;
  end

  always @(negedge clk_i) begin
    if (mdl_rst) begin
      rx_n = 0; bitc = 0; edges_after = 0; lo_ctr = 0; hi_ctr = 0; last_lo = 0;
      model_init = 1'b1; model_done = 1'b0; rel_pend = 1'b0;
    end else begin
      if (cclk_o && !prev_cclk) begin
        shreg = {shreg[6:0], dout_o};
        bitc++;
        if (done_i) edges_after++;
        if (bitc == 8) begin
          if (rx_n < 64) rx[rx_n] = shreg;
          rx_n++;
          bitc = 0;
          if (done_at >= 0 && rx_n == done_at) model_done = 1'b1;
        end
      end
      if (!prog_n_o) begin
        lo_ctr++;
        hi_ctr = 0;
        if (lo_ctr >= 3 && !no_init_low) begin
          model_init = 1'b0;
          rel_pend = 1'b1;
        end
      end else begin
        if (lo_ctr > 0) last_lo = lo_ctr;
        lo_ctr = 0;
        hi_ctr++;
        if (hi_ctr == 5 && rel_pend && !stuck_rel) begin
          model_init = 1'b1;
          rel_pend = 1'b0;
        end
      end
    end
    prev_cclk = cclk_o;
    valid_i = feed_en && (acc_n < feed_lim) && ($urandom_range(0, 3) != 0);
    byte_i  = tx[acc_n[3:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    @(negedge clk_i) mdl_rst = 1'b1;
    @(negedge clk_i) mdl_rst = 1'b0;
  endtask

  task automatic go(input int n);
    @(negedge clk_i);
    len_i = LEN_W'(n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input int lim, output int waited);
    waited = 0;
    while (busy_o && waited < lim) begin
      @(negedge clk_i);
      waited++;
    end
  endtask

  task automatic wait_rx(input int k);
    int g = 0;
    while ((rx_n < k || bitc != 0) && g < 5000) begin
      @(negedge clk_i);
      g++;
    end
  endtask

  function automatic int count_data_bad(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rx[i] != tx[i]) bad++;
    return bad;
  endfunction

  function automatic int count_fill_bad(input int from, input int upto);
    int bad = 0;
    for (int i = from; i < upto && i < 64; i++) if (rx[i] != 8'hFF) bad++;
    return bad;
  endfunction

  task automatic run_normal(input int n, input int extra);
    int w;
    model_reset();
    for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
    done_at = n + 1 + extra;
    feed_lim = n;
    feed_en = 1'b1;
    go(n);
    check(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
    check(result_o == 3'd0, "R11", "result cleared at start", result_o, 0);
    wait_idle(5000, w);
    check(result_o == 3'd1, "R8", "normal result", result_o, 1);
    check(last_lo >= PROG_CYC, "R1", "program low cycles", last_lo, PROG_CYC);
    check(acc_n == n, "R5", "bytes accepted", acc_n, n);
    check(count_data_bad(n) == 0, "R4", "MSB-first data mismatches", count_data_bad(n), 0);
    check(count_fill_bad(n, rx_n) == 0, "R8", "non-0xFF filler bytes", count_fill_bad(n, rx_n), 0);
    check(edges_after >= 8 && edges_after <= 16, "R8", "edges after done", edges_after, 8);
    check(bitc == 0, "R8", "partial byte at end", bitc, 0);
    check(prog_n_o && cclk_o, "R4", "lines idle high", {prog_n_o, cclk_o}, 3);
    feed_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual busy %0d expected finish", busy_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) tx[i] = '0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    check(prog_n_o == 1'b1, "R11", "reset program line", prog_n_o, 1);
    check(cclk_o == 1'b1, "R11", "reset clock", cclk_o, 1);
    check(busy_o == 1'b0 && ready_o == 1'b0, "R11", "reset busy/ready", {busy_o, ready_o}, 0);
    check(result_o == 3'd0, "R11", "reset result", result_o, 0);

    // random loads with random stream gaps
    for (int t = 0; t < 5; t++) run_normal($urandom_range(1, 10), $urandom_range(0, 3));

    // zero-length image: filler only
    run_normal(0, 1);

    // early done at a byte boundary
    model_reset();
    for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
    done_at = -1; feed_lim = 3; feed_en = 1'b1;
    go(8);
    wait_rx(3);
    repeat (4) @(negedge clk_i);
    force_done = 1'b1;
    repeat (10) @(negedge clk_i);
    feed_lim = 8;
    wait_idle(5000, w);
    check(result_o == 3'd1, "R7", "early done result", result_o, 1);
    check(acc_n == 3, "R7", "bytes after early done", acc_n, 3);
    check(rx_n == 4 && rx[3] == 8'hFF, "R7", "one filler after early done", rx_n, 4);
    force_done = 1'b0; feed_en = 1'b0;

    // init low at a byte boundary
    model_reset();
    done_at = -1; feed_lim = 5; feed_en = 1'b1;
    go(8);
    wait_rx(5);
    repeat (4) @(negedge clk_i);
    force_init_lo = 1'b1;
    repeat (10) @(negedge clk_i);
    feed_lim = 8;
    wait_idle(5000, w);
    check(result_o == 3'd3, "R6", "load error result", result_o, 3);
    check(err_off_o == 8'd5, "R6", "error offset", err_off_o, 5);
    check(acc_n == 5 && rx_n == 5, "R6", "bytes stopped", acc_n, 5);
    check(prog_n_o == 1'b1, "R6", "program released", prog_n_o, 1);
    force_init_lo = 1'b0; feed_en = 1'b0;

    // init never falls
    model_reset();
    no_init_low = 1'b1; done_at = 1; feed_lim = 2; feed_en = 1'b1;
    go(2);
    wait_idle(5000, w);
    check(result_o == 3'd2, "R2", "init never low", result_o, 2);
    check(w >= 185 && w <= 225, "R2", "init timeout cycles", w, INIT_US * US_DIV);
    check(prog_n_o == 1'b1 && rx_n == 0, "R2", "released, no data", rx_n, 0);
    no_init_low = 1'b0;

    // init never returns high after release
    model_reset();
    stuck_rel = 1'b1;
    go(2);
    wait_idle(5000, w);
    check(result_o == 3'd2, "R2", "init stuck low", result_o, 2);
    check(acc_n == 0 && rx_n == 0, "R3", "no data before init high", acc_n, 0);
    stuck_rel = 1'b0; feed_en = 1'b0;

    // done never comes
    model_reset();
    for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
    done_at = -1; feed_lim = 2; feed_en = 1'b1;
    go(2);
    wait_idle(8000, w);
    check(result_o == 3'd4, "R9", "done timeout result", result_o, 4);
    check(rx_n > 22, "R9", "filler bytes before timeout", rx_n, 23);
    check(count_data_bad(2) == 0 && count_fill_bad(2, rx_n) == 0, "R8",
          "data then filler", count_fill_bad(2, rx_n), 0);
    feed_en = 1'b0;

    // abort during loading
    model_reset();
    done_at = -1; feed_lim = 10; feed_en = 1'b1;
    go(10);
    wait_rx(2);
    @(negedge clk_i) abort_i = 1'b1;
    @(negedge clk_i) abort_i = 1'b0;
    check(result_o == 3'd5, "R10", "abort result", result_o, 5);
    check(prog_n_o && cclk_o, "R10", "lines high after abort", {prog_n_o, cclk_o}, 3);
    check(!busy_o && !ready_o, "R10", "idle after abort", busy_o, 0);
    feed_en = 1'b0;
    repeat (20) @(negedge clk_i);
    check(result_o == 3'd5, "R11", "result held", result_o, 5);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule